// File: doc/BRIEF.md
# Vector Mask Compress/Expand Unit

This unit rearranges the elements of one vector register under the control of a mask that holds one bit per element. In compress mode, every element whose mask bit is set is moved toward the front of the destination. These elements land in consecutive slots starting at slot 0 and keep their relative order. The number of packed elements is reported as the count, which is the population count of the mask. In expand mode the unit does the reverse. The first source element goes to the slot of the lowest set mask bit, the next source element goes to the next set bit, and so on.

The unit captures a whole operation (mode, active length, source vector, mask and the previous destination contents) when `start` is accepted. It then walks the mask one element per clock and asserts `done` for a single cycle. Elements at or above the active length take no part. Destination slots that are not written keep their previous value. The `ready`/`start` pair behaves like a valid/ready handshake on the command side. A command transfers on a clock edge where both are high. `ready` is low while an operation is in flight, and `start` is ignored then, so the caller simply holds `start` until it sees `ready`. There is no back-pressure on results: `dst_vec` and `count` are valid from the `done` cycle and are held until the next accepted command.

Top module: `vmpk_unit`

## Requirements
- R1: With `mode`=0 (compress), the elements i < active length whose mask bit i is 1 appear in `dst_vec` slots 0, 1, 2, ... in increasing order of i. Element k occupies bits [k*EW +: EW].
- R2: At `done` and afterwards until the next accepted start, `count` equals the number of set mask bits below the active length.
- R3: With `mode`=1 (expand), the n-th set mask bit below the active length (counting from 0) receives source element n.
- R4: Slots that are not written keep the value given on `dst_init` at start. In compress, these are slots at or above `count`. In expand, these are slots whose mask bit is 0 or that lie at or above the active length.
- R5: The active length is `vl`, clamped to VLMAX. Mask bits at or above it have no effect on `dst_vec` or `count`.
- R6: `done` is high for exactly one cycle. It is seen after vl_active+1 rising edges, counting the edge that accepted start, so a length of 0 completes after one edge.
- R7: `ready` is high only when idle. A `start` while `ready` is low is ignored, and input changes after acceptance do not affect the running operation.
- R8: An all-zero mask gives `count`=0 and `dst_vec`=`dst_init`. An all-ones mask with full length makes both modes copy `src_vec` unchanged.
- R9: After reset, `ready`=1, `done`=0, `count`=0 and `dst_vec`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command valid; accepted when ready is high |
| ready | output | 1 | Unit idle and able to accept a command |
| mode | input | 1 | 0 = compress, 1 = expand |
| vl | input | $clog2(VLMAX+1) | Requested active vector length |
| src_vec | input | VLMAX*EW | Source vector, element k at bits [k*EW +: EW] |
| mask | input | VLMAX | One mask bit per element |
| dst_init | input | VLMAX*EW | Previous destination contents |
| dst_vec | output | VLMAX*EW | Result vector |
| count | output | $clog2(VLMAX+1) | Packed length (mask popcount within length) |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the assertions check the following. The control sequence never accepts work while busy. `done` lasts one cycle, and a zero-length command finishes at once. The walk index stays below the latched length. The pack pointer never runs ahead of the element index and only advances on set mask bits. The final count matches a popcount taken independently at acceptance. Results are also held steady while idle. Only the bench scenarios can show that the right element reaches the right slot in each mode. The same holds for untouched slots keeping their old values, for mask bits beyond the length being ignored, and for mid-operation input changes and refused starts leaving the result unchanged.

// File: rtl/vmpk_pkg.sv
package vmpk_pkg;
  typedef enum logic {
    MODE_COMPRESS = 1'b0,
    MODE_EXPAND   = 1'b1
  } vmpk_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } vmpk_state_e;
endpackage

// File: rtl/vmpk_mask_trim.sv
module vmpk_mask_trim #(
  parameter int VLMAX = 16,
  parameter int LW    = $clog2(VLMAX + 1)
) (
  input  logic [LW-1:0]    vl,
  input  logic [VLMAX-1:0] mask,
  output logic [LW-1:0]    vl_eff,
  output logic [VLMAX-1:0] mask_eff,
  output logic [LW-1:0]    pop
);
  localparam logic [LW-1:0] VLMAX_L = LW'(VLMAX);

  assign vl_eff = (vl > VLMAX_L) ? VLMAX_L : vl;

  for (genvar k = 0; k < VLMAX; k++) begin : g_trim
    localparam logic [LW-1:0] KPOS = LW'(k);
    assign mask_eff[k] = mask[k] & (KPOS < vl_eff);
  end

  always_comb begin
    pop = '0;
    for (int k = 0; k < VLMAX; k++) begin
      pop = pop + LW'(mask_eff[k]);
    end
  end
endmodule

// File: rtl/vmpk_seq.sv
module vmpk_seq
  import vmpk_pkg::*;
#(
  parameter int VLMAX = 16,
  parameter int LW    = $clog2(VLMAX + 1),
  parameter int IW    = $clog2(VLMAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] vl_eff,
  output logic          ready,
  output logic          load,
  output logic          run,
  output logic [IW-1:0] elem_idx,
  output logic          done
);
  vmpk_state_e   state_q;
  logic [IW-1:0] idx_q;
  logic [LW-1:0] len_q;
  logic          last;

  assign ready    = (state_q == ST_IDLE);
  assign run      = (state_q == ST_RUN);
  assign done     = (state_q == ST_DONE);
  assign load     = start & ready;
  assign elem_idx = idx_q;
  assign last     = (LW'(idx_q) + LW'(1)) == len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      len_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            len_q   <= vl_eff;
            idx_q   <= '0;
            state_q <= (vl_eff == '0) ? ST_DONE : ST_RUN;
          end
        end
        ST_RUN: begin
          if (last) state_q <= ST_DONE;
          else      idx_q   <= idx_q + IW'(1);
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (load && vl_eff == '0) |=> done);
  a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (run || done) |-> !ready);
  a_r5_idx_in_len: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (LW'(elem_idx) < len_q));
endmodule

// File: rtl/vmpk_lane_store.sv
module vmpk_lane_store
  import vmpk_pkg::*;
#(
  parameter int VLMAX = 16,
  parameter int EW    = 8,
  parameter int LW    = $clog2(VLMAX + 1),
  parameter int IW    = $clog2(VLMAX),
  localparam int VW   = VLMAX * EW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             mode,
  input  logic [VW-1:0]    src_vec,
  input  logic [VLMAX-1:0] mask_eff,
  input  logic [VW-1:0]    dst_init,
  input  logic             run,
  input  logic [IW-1:0]    elem_idx,
  output logic [VW-1:0]    dst_vec,
  output logic [LW-1:0]    count
);
  vmpk_mode_e       mode_q;
  logic [VW-1:0]    src_q;
  logic [VLMAX-1:0] mask_q;
  logic [LW-1:0]    ptr_q;
  logic [EW-1:0]    dst_q [VLMAX];
  logic [IW-1:0]    ptr_idx;
  logic             take;
  logic [EW-1:0]    src_at_idx;
  logic [EW-1:0]    src_at_ptr;

  assign ptr_idx    = ptr_q[IW-1:0];
  assign take       = run & mask_q[elem_idx];
  assign src_at_idx = src_q[EW*int'(elem_idx) +: EW];
  assign src_at_ptr = src_q[EW*int'(ptr_idx) +: EW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_COMPRESS;
      src_q  <= '0;
      mask_q <= '0;
      ptr_q  <= '0;
      for (int k = 0; k < VLMAX; k++) dst_q[k] <= '0;
    end else if (load) begin
      mode_q <= vmpk_mode_e'(mode);
      src_q  <= src_vec;
      mask_q <= mask_eff;
      ptr_q  <= '0;
      for (int k = 0; k < VLMAX; k++) dst_q[k] <= dst_init[EW*k +: EW];
    end else if (take) begin
      if (mode_q == MODE_COMPRESS) dst_q[ptr_idx]  <= src_at_idx;
      else                         dst_q[elem_idx] <= src_at_ptr;
      ptr_q <= ptr_q + LW'(1);
    end
  end

  for (genvar k = 0; k < VLMAX; k++) begin : g_flat
    assign dst_vec[EW*k +: EW] = dst_q[k];
  end

  assign count = ptr_q;

  a_r1_ptr_behind_idx: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (ptr_q <= LW'(elem_idx)));
  a_r2_ptr_only_on_set: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !mask_q[elem_idx]) |=> $stable(ptr_q));
  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> ($stable(dst_vec) && $stable(ptr_q)));
endmodule

// File: rtl/vmpk_unit.sv
module vmpk_unit #(
  parameter int VLMAX = 16,
  parameter int EW    = 8,
  localparam int LW   = $clog2(VLMAX + 1),
  localparam int IW   = $clog2(VLMAX),
  localparam int VW   = VLMAX * EW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             ready,
  input  logic             mode,
  input  logic [LW-1:0]    vl,
  input  logic [VW-1:0]    src_vec,
  input  logic [VLMAX-1:0] mask,
  input  logic [VW-1:0]    dst_init,
  output logic [VW-1:0]    dst_vec,
  output logic [LW-1:0]    count,
  output logic             done
);
  logic [LW-1:0]    vl_eff;
  logic [VLMAX-1:0] mask_eff;
  logic [LW-1:0]    pop;
  logic             load;
  logic             run;
  logic [IW-1:0]    elem_idx;
  logic [LW-1:0]    pop_q;

  vmpk_mask_trim #(.VLMAX(VLMAX), .LW(LW)) trim_i (
    .vl(vl), .mask(mask), .vl_eff(vl_eff), .mask_eff(mask_eff), .pop(pop)
  );

  vmpk_seq #(.VLMAX(VLMAX), .LW(LW), .IW(IW)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_eff(vl_eff),
    .ready(ready), .load(load), .run(run), .elem_idx(elem_idx), .done(done)
  );

  vmpk_lane_store #(.VLMAX(VLMAX), .EW(EW), .LW(LW), .IW(IW)) store_i (
    .clk(clk), .rst_n(rst_n), .load(load), .mode(mode), .src_vec(src_vec),
    .mask_eff(mask_eff), .dst_init(dst_init), .run(run), .elem_idx(elem_idx),
    .dst_vec(dst_vec), .count(count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pop_q <= '0;
    else if (load) pop_q <= pop;
  end

  a_r2_count_is_pop: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (count == pop_q));
  a_r7_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && start) |=> $stable(pop_q));
endmodule

// File: tb/vmpk_unit_tb_top.sv
module vmpk_unit_tb_top;
  localparam int VLMAX = 16;
  localparam int EW    = 8;
  localparam int LW    = $clog2(VLMAX + 1);
  localparam int VW    = VLMAX * EW;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             ready;
  logic             mode = 1'b0;
  logic [LW-1:0]    vl = '0;
  logic [VW-1:0]    src_vec = '0;
  logic [VLMAX-1:0] mask = '0;
  logic [VW-1:0]    dst_init = '0;
  logic [VW-1:0]    dst_vec;
  logic [LW-1:0]    count;
  logic             done;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  vmpk_unit #(.VLMAX(VLMAX), .EW(EW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .mode(mode),
    .vl(vl), .src_vec(src_vec), .mask(mask), .dst_init(dst_init),
    .dst_vec(dst_vec), .count(count), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [VW-1:0] act,
                       input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input bit md, input int len, input logic [VW-1:0] s,
                                input logic [VLMAX-1:0] m, input logic [VW-1:0] init,
                                output logic [VW-1:0] d, output int c);
    int le;
    le = (len > VLMAX) ? VLMAX : len;
    d = init;
    c = 0;
    for (int i = 0; i < le; i++) begin
      if (m[i]) begin
        if (!md) d[c*EW +: EW] = s[i*EW +: EW];
        else     d[i*EW +: EW] = s[c*EW +: EW];
        c++;
      end
    end
  endfunction

  task automatic run_op(input bit md, input int len, input logic [VW-1:0] s,
                        input logic [VLMAX-1:0] m, input logic [VW-1:0] init,
                        input bit poke, input string req);
    logic [VW-1:0] exp_d;
    int exp_c, le, lat;
    model(md, len, s, m, init, exp_d, exp_c);
    le = (len > VLMAX) ? VLMAX : len;
    @(negedge clk);
    check(ready === 1'b1, {req, " R7 ready idle"}, VW'(ready), VW'(1));
    start = 1'b1; mode = md; vl = LW'(len); src_vec = s; mask = m; dst_init = init;
    @(posedge clk);
    lat = 1;
    @(negedge clk);
    if (poke && le >= 1) begin
      start = 1'b1; mode = ~md; vl = LW'(VLMAX); src_vec = ~s; mask = ~m;
      dst_init = ~init;
      check(ready === 1'b0, {req, " R7 busy not ready"}, VW'(ready), VW'(0));
    end else begin
      start = 1'b0;
    end
    while (!done && lat < 64) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      start = 1'b0;
    end
    check(lat == le + 1, {req, " R6 latency"}, VW'(lat), VW'(le + 1));
    check(dst_vec === exp_d, {req, " R1/R3/R4 dst"}, dst_vec, exp_d);
    check(int'(count) == exp_c, {req, " R2 count"}, VW'(count), VW'(exp_c));
    @(posedge clk);
    @(negedge clk);
    check(done === 1'b0, {req, " R6 single pulse"}, VW'(done), VW'(0));
    check(dst_vec === exp_d && int'(count) == exp_c, {req, " R2 held"}, dst_vec, exp_d);
  endtask

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] v;
    for (int k = 0; k < VW / 32; k++) v[k*32 +: 32] = $urandom();
    return v;
  endfunction

  initial begin : watchdog
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [VW-1:0] s, init;
    void'($urandom(32'h1BADC0DE));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready === 1'b1 && done === 1'b0, "R9 reset ctrl", VW'({ready, done}), VW'(2));
    check(count === '0 && dst_vec === '0, "R9 reset data", dst_vec, '0);

    s = rand_vec(); init = rand_vec();
    run_op(1'b0, 16, s, 16'h0000, init, 1'b0, "R8 zero mask compress");
    run_op(1'b1, 16, s, 16'h0000, init, 1'b0, "R8 zero mask expand");
    run_op(1'b0, 16, s, 16'hFFFF, init, 1'b0, "R8 ones compress");
    run_op(1'b1, 16, s, 16'hFFFF, init, 1'b0, "R8 ones expand");
    run_op(1'b0, 0, s, 16'hFFFF, init, 1'b0, "R5 R6 zero length");
    run_op(1'b0, 5, s, 16'hFFF5, init, 1'b0, "R5 mask beyond length");
    run_op(1'b1, 7, s, 16'hAAAA, init, 1'b0, "R5 R3 expand short");
    run_op(1'b0, 17, s, 16'h8001, init, 1'b0, "R5 clamp length");
    run_op(1'b1, 16, s, 16'h5555, init, 1'b0, "R3 alternating");
    run_op(1'b0, 16, s, 16'h8421, init, 1'b0, "R1 sparse");
    run_op(1'b0, 12, s, 16'h0F3C, init, 1'b1, "R7 poke compress");
    run_op(1'b1, 1, s, 16'h0001, init, 1'b1, "R7 poke expand");

    for (int n = 0; n < 60; n++) begin
      run_op(1'($urandom_range(0, 1)), int'($urandom_range(0, 18)), rand_vec(),
             VLMAX'($urandom()), rand_vec(), 1'($urandom_range(0, 1)), "R1 R3 random");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule